// File: doc/BRIEF.md
# Presettable Modulo-16 Counter with Carry Enables

A synchronous binary up-counter, four bits wide by default, that steps through all of its states and rolls from the top value back to zero. It can take a new value from a parallel data word on a clock edge. An active-low reset clears it at once, without waiting for a clock edge.

Counting needs two enables. The parallel enable takes part only in the increment decision. The trickle enable takes part in the increment decision and also gates the terminal-count output. Because of this split, several stages can be joined into one wider synchronous counter using lookahead carry. The terminal count of the lowest stage feeds the parallel enable of every higher stage. Each stage's terminal count feeds the trickle enable of the stage above it.

The load, count and hold modes are decoded in a fixed order of priority. A registered state stage acts on the decoded mode at each rising edge, and a combinational terminal-count decoder watches the state.

Top module: `sync_preset_ctr`

## Requirements
- R1: The count is modulo 2^WIDTH. When the count is all ones and a count step occurs, the count becomes zero.
- R2: While rst_n is low, count and tc are zero. This takes effect as soon as rst_n falls, with no clock edge needed.
- R3: With rst_n high and load_n low, count takes the value of din on the next rising clock edge, whatever en_par and en_trk are.
- R4: With rst_n and load_n high, count increases by one on a rising edge when en_par and en_trk are both high.
- R5: With rst_n and load_n high, count keeps its value across a rising edge when en_par or en_trk is low.
- R6: tc is 1 exactly when count is all ones and en_trk is 1. en_par has no effect on tc.
- R7: tc follows en_trk combinationally. A change of en_trk shows on tc within the same clock period, with no clock edge.
- R8: STAGES copies joined in lookahead style form a counter of STAGES*WIDTH bits that counts, loads and wraps as one counter. Stage 0 gets the common enable on both of its enables. Every higher stage gets stage 0's tc on en_par and the tc of the stage below it on en_trk.
- R9: Reset has priority over load and count. Clock edges that occur while rst_n is low leave count at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes other than reset happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| load_n | input | 1 | Active-low parallel load request |
| en_par | input | 1 | Count enable used only in the step decision |
| en_trk | input | 1 | Count enable that also gates tc |
| din | input | WIDTH | Parallel data to load |
| count | output | WIDTH | Current count |
| tc | output | 1 | Terminal count: count all ones and en_trk high |

## Verification
Load, count and hold results show one rising edge after the inputs are applied. The bench drives inputs at the falling edge and samples count 1 ns after the following rising edge. tc and reset results take effect with no edge. The bench changes en_trk or lowers rst_n in the middle of a clock period and samples 1 ns later, before any edge. In the cascaded run, the combined value is compared on every cycle with an integer reference that the bench updates at each edge.

// File: rtl/ctr_pkg.sv
// Package: shared types for the presettable counter.
// Assumes: nothing; pure type definitions.
package ctr_pkg;

    // Decoded synchronous action for the next rising edge
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2
    } ctr_mode_e;

endpackage

// File: rtl/ctr_mode_decode.sv
// Module: ctr_mode_decode
// Chooses the synchronous action in priority order: load, then count,
// then hold. Reset is not decoded here; the state register handles it.
// Assumes: inputs are stable around the rising clock edge.
module ctr_mode_decode
    import ctr_pkg::*;
(
    input  logic      load_n,
    input  logic      en_par,
    input  logic      en_trk,
    output ctr_mode_e mode
);

    // Priority select of the next-edge action
    always_comb begin
        if (!load_n) begin
            mode = MODE_LOAD;
        end else if (en_par && en_trk) begin
            mode = MODE_COUNT;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/ctr_state_reg.sv
// Module: ctr_state_reg
// Holds the count. Clears asynchronously on rst_n low. Otherwise it
// loads, increments with wrap, or holds on each rising edge.
// Assumes: mode is decoded from inputs that are stable at the edge.
module ctr_state_reg
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctr_mode_e        mode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Count register with asynchronous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case (mode)
                MODE_LOAD:  count <= din;
                MODE_COUNT: count <= count + ONE;
                default:    count <= count;
            endcase
        end
    end

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> (count == $past(din)));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COUNT) |=> (count == $past(count) + ONE));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(count));

endmodule

// File: rtl/ctr_terminal.sv
// Module: ctr_terminal
// Flags the top state, gated by the trickle enable only. The output is
// combinational so that it follows en_trk with no clock edge.
// Assumes: the flag is not used as a clock or asynchronous reset.
module ctr_terminal #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             en_trk,
    output logic             tc
);

    localparam logic [WIDTH-1:0] TOP = '1;

    // Terminal-count decode
    always_comb begin
        tc = en_trk && (count == TOP);
    end

endmodule

// File: rtl/sync_preset_ctr.sv
// Module: sync_preset_ctr
// Presettable binary up-counter with a parallel and a trickle enable
// and a terminal-count output for lookahead cascading.
// Assumes: rst_n deassertion is synchronised to clk by the caller.
module sync_preset_ctr
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             en_par,
    input  logic             en_trk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             tc
);

    localparam logic [WIDTH-1:0] TOP = '1;

    ctr_mode_e mode;

    ctr_mode_decode u_decode (
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .mode   (mode)
    );

    ctr_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .din    (din),
        .count  (count)
    );

    ctr_terminal #(.WIDTH(WIDTH)) u_term (
        .count  (count),
        .en_trk (en_trk),
        .tc     (tc)
    );

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && mode == MODE_COUNT) |=> (count == '0));

    p_tc_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (count == TOP));

endmodule

// File: tb/tb_sync_preset_ctr.sv
`timescale 1ns/1ps

// Lookahead cascade of counter stages used by the bench (R8)
module ctr_chain #(
    parameter int STAGES = 3,
    parameter int WIDTH  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_n,
    input  logic                    en,
    input  logic [STAGES*WIDTH-1:0] din,
    output logic [STAGES*WIDTH-1:0] value,
    output logic                    carry
);
    logic [STAGES-1:0] tcs;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic par_in;
        logic trk_in;
        if (i == 0) begin : g_first
            assign par_in = en;
            assign trk_in = en;
        end else begin : g_rest
            assign par_in = tcs[0];
            assign trk_in = tcs[i-1];
        end
        sync_preset_ctr #(.WIDTH(WIDTH)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_n (load_n),
            .en_par (par_in),
            .en_trk (trk_in),
            .din    (din[i*WIDTH +: WIDTH]),
            .count  (value[i*WIDTH +: WIDTH]),
            .tc     (tcs[i])
        );
    end

    assign carry = tcs[STAGES-1];
endmodule

module tb_sync_preset_ctr;
    localparam int W      = 4;
    localparam int STAGES = 3;
    localparam int TW     = STAGES * W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n = 1'b0, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] count;
    logic         tc;

    logic          c_rst_n = 1'b0, c_load_n = 1'b1, c_en = 1'b0;
    logic [TW-1:0] c_din = '0;
    logic [TW-1:0] c_value;
    logic          c_carry;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    sync_preset_ctr #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .din(din), .count(count), .tc(tc)
    );

    ctr_chain #(.STAGES(STAGES), .WIDTH(W)) u_chain (
        .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .en(c_en),
        .din(c_din), .value(c_value), .carry(c_carry)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive at falling edge, then sample just after the next rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R2 reset count", int'(count), 0);
        chk("R2 reset tc", int'(tc), 0);
        rst_n = 1'b1;
        c_rst_n = 1'b1;
    endtask

    task automatic t_load();
        @(negedge clk);
        load_n = 1'b0; en_par = 1'b0; en_trk = 1'b0; din = 4'd10;
        step();
        chk("R3 load with enables low", int'(count), 10);
        @(negedge clk);
        en_par = 1'b1; en_trk = 1'b1; din = 4'd3;
        step();
        chk("R3 load overrides count", int'(count), 3);
        @(negedge clk);
        load_n = 1'b1;
    endtask

    task automatic t_count_wrap();
        int exp_v;
        @(negedge clk);
        load_n = 1'b0; din = 4'd12;
        step();
        @(negedge clk);
        load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;
        exp_v = 12;
        for (int i = 0; i < 20; i++) begin
            step();
            exp_v = (exp_v + 1) % 16;
            chk((exp_v == 0) ? "R1 wrap to zero" : "R4 increment", int'(count), exp_v);
        end
    endtask

    task automatic t_hold();
        logic [W-1:0] was;
        @(negedge clk);
        was = count;
        en_par = 1'b0; en_trk = 1'b1;
        step(); step();
        chk("R5 hold with en_par low", int'(count), int'(was));
        @(negedge clk);
        en_par = 1'b1; en_trk = 1'b0;
        step(); step();
        chk("R5 hold with en_trk low", int'(count), int'(was));
    endtask

    task automatic t_terminal();
        @(negedge clk);
        load_n = 1'b0; din = 4'd15; en_par = 1'b0; en_trk = 1'b0;
        step();
        @(negedge clk);
        load_n = 1'b1;
        #1;
        chk("R6 tc low with en_trk low", int'(tc), 0);
        en_trk = 1'b1;
        #1;
        chk("R7 tc rises with en_trk, no edge", int'(tc), 1);
        en_par = 1'b1;
        #1;
        en_par = 1'b0;
        #1;
        chk("R6 en_par has no effect on tc", int'(tc), 1);
        en_trk = 1'b0;
        #1;
        chk("R7 tc falls with en_trk, no edge", int'(tc), 0);
        @(negedge clk);
        load_n = 1'b0; din = 4'd14; en_trk = 1'b1;
        step();
        chk("R6 tc low below top", int'(tc), 0);
        @(negedge clk);
        load_n = 1'b1;
    endtask

    task automatic t_async_reset();
        @(negedge clk);
        load_n = 1'b0; din = 4'd9;
        step();
        @(negedge clk);
        load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
        @(posedge clk);
        #3;
        rst_n = 1'b0;
        #1;
        chk("R2 clear without clock edge", int'(count), 0);
        load_n = 1'b0; din = 4'd5; en_par = 1'b1; en_trk = 1'b1;
        step(); step();
        chk("R9 reset beats load and count", int'(count), 0);
        @(negedge clk);
        rst_n = 1'b1; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
    endtask

    task automatic t_chain_full();
        int ref_v;
        int top;
        top = (1 << TW) - 1;
        @(negedge clk);
        c_load_n = 1'b1; c_en = 1'b1;
        ref_v = int'(c_value);
        chk("R8 chain start", ref_v, 0);
        for (int i = 0; i < (1 << TW) + 8; i++) begin
            if (ref_v == top) begin
                chk("R8 chain carry at top", int'(c_carry), 1);
            end
            step();
            ref_v = (ref_v + 1) % (1 << TW);
            if (int'(c_value) != ref_v) begin
                chk("R8 chain count", int'(c_value), ref_v);
            end else begin
                n_checks++;
            end
        end
    endtask

    task automatic t_chain_random();
        int ref_v;
        int r;
        ref_v = int'(c_value);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            r = int'($urandom % 16);
            c_rst_n  = (r != 0);
            c_load_n = !(r == 1 || r == 2);
            c_din    = TW'($urandom);
            c_en     = ($urandom % 4) != 0;
            if (r == 0) begin
                ref_v = 0;
            end else if (!c_load_n) begin
                ref_v = int'(c_din);
            end else if (c_en) begin
                ref_v = (ref_v + 1) % (1 << TW);
            end
            step();
            chk("R8 chain random", int'(c_value), ref_v);
        end
        @(negedge clk);
        c_rst_n = 1'b1; c_load_n = 1'b1; c_en = 1'b0;
    endtask

    initial begin
        #3;
        t_reset_state();
        t_load();
        t_count_wrap();
        t_hold();
        t_terminal();
        t_async_reset();
        t_chain_full();
        t_chain_random();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule